// File: doc/BRIEF.md
# Two-Channel External Interrupt Controller

This block takes two asynchronous interrupt pins from outside the chip and turns them into one interrupt request for the CPU. Each pin has its own 8-bit status/control register on a plain register bus with an address, a write strobe, write data and combinational read data. Software chooses, for each channel, one of four trigger conditions. Two are pure edges (falling or rising). The other two combine an edge with the matching level, so the request keeps being raised while the pin stays active.

Each pin is resynchronised before any detection is done. When the chosen condition occurs and the channel is enabled, a sticky flag is set. Software clears the flag by writing a one to a dedicated clear bit, and that bit always reads back as zero. The synchronised pin level can be read in the same register. Both channels drive one shared request line, and software reads the two flags to find out which pin fired.

Top module: `extirq_ctrl`

## Requirements
- R1: After a synchronous reset with `rst_n` low, every register reads 0x00 and `irq` is low.
- R2: Channel k sits at bus address k (k = 0, 1), and `rd_data` is combinational from `addr`. The bit fields are: bit 5 = flag, bit 4 = enable, bit 3 = LV, bit 2 = EDG, bit 1 = clear (always reads 0), bit 0 = pin level. Bits 7 and 6 always read 0.
- R3: With {LV,EDG} = 00, a falling edge on the pin sets the flag. A rising edge does not set it.
- R4: With {LV,EDG} = 01, a rising edge on the pin sets the flag. A clear written while the pin stays high keeps the flag clear.
- R5: With {LV,EDG} = 10, the flag is set on a falling edge and on every cycle in which the synchronised pin is low. A clear written while the pin is low is overridden.
- R6: With {LV,EDG} = 11, the flag is set on a rising edge and on every cycle in which the synchronised pin is high. A clear takes effect once the pin has gone low.
- R7: Writing a one to bit 1 clears the flag on the next clock edge, provided no enabled trigger occurs in the same cycle.
- R8: Bit 0 follows the pin through a two-flop synchronizer. A pin change shows in bit 0 after the second rising clock edge that follows it.
- R9: A channel whose enable bit is 0 never sets its flag. Enabling the channel after an edge has already passed does not set the flag.
- R10: `irq` is high exactly when some channel has both its flag and its enable set. Clearing the enable keeps the flag but drops that channel's share of `irq`.
- R11: When an enabled trigger and a clear write fall in the same cycle, the flag ends up set.
- R12: Writes to bit 5 and bit 0 are ignored. Only enable, LV and EDG store written values.
- R13: Activity on one pin and writes to one channel's register leave the other channel's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_CH | Asynchronous external interrupt pins |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| irq | output | 1 | Shared interrupt request |

## Verification
Each of the four sensitivity codes is driven with a rising pulse, with a falling pulse, and with a pin held at one level while clears are written. This separates the edge-only modes from the edge-plus-level modes: only the level modes re-set a flag that software has just cleared. A pin is also toggled while its channel is disabled, and the channel is enabled afterwards, which shows that a missed edge is not remembered. A pin change is read back one edge and two edges later to pin down the synchronizer latency. A behavioural model that steps once per clock checks the read data and the request line on every cycle.

// File: rtl/extirq_pkg.sv
// Package: shared field positions and types for the external interrupt controller.
// Assumes an 8-bit register per channel.
package extirq_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_FLAG = 5;
    localparam int BIT_EN   = 4;
    localparam int BIT_LV   = 3;
    localparam int BIT_EDG  = 2;
    localparam int BIT_CLR  = 1;
    localparam int BIT_PIN  = 0;

    // Sensitivity code as {LV, EDG}
    typedef enum logic [1:0] {
        SENS_FALL      = 2'b00,
        SENS_RISE      = 2'b01,
        SENS_FALL_LOW  = 2'b10,
        SENS_RISE_HIGH = 2'b11
    } sens_e;
endpackage

// File: rtl/extirq_sync.sv
// Module: resynchronises one asynchronous pin through STAGES flops, then keeps
// one more sample so that edges can be seen.
// Assumes STAGES >= 2. All outputs are registered-domain signals.
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin into the synchronizer and keep the last synchronised sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/extirq_sense.sv
// Module: combinational trigger decode for one channel from the sensitivity code.
// Assumes level/rise/fall come from extirq_sync.
module extirq_sense
    import extirq_pkg::*;
(
    input  sens_e sens,
    input  logic  level,
    input  logic  rise,
    input  logic  fall,
    output logic  trig
);
    // Select the trigger condition for the current sensitivity code
    always_comb begin
        unique case (sens)
            SENS_FALL:      trig = fall;
            SENS_RISE:      trig = rise;
            SENS_FALL_LOW:  trig = fall | ~level;
            SENS_RISE_HIGH: trig = rise | level;
            default:        trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/extirq_channel.sv
// Module: one interrupt channel, made of the synchronizer, the trigger decode,
// the control storage and the sticky flag.
// Assumes wr_sel is already qualified with the address hit for this channel.
module extirq_channel
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_word,
    output logic             flag,
    output logic             en,
    output logic             trig,
    output logic             clr
);
    logic  level, rise, fall;
    sens_e sens;
    logic  unused_bits;

    extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin),
        .level (level),
        .rise  (rise),
        .fall  (fall)
    );

    extirq_sense u_sense (
        .sens  (sens),
        .level (level),
        .rise  (rise),
        .fall  (fall),
        .trig  (trig)
    );

    assign clr         = wr_sel & wr_data[BIT_CLR];
    assign unused_bits = ^{wr_data[7:6], wr_data[BIT_FLAG], wr_data[BIT_PIN]};

    // Store the enable and sensitivity fields on a write to this channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            sens <= SENS_FALL;
        end else if (wr_sel) begin
            en   <= wr_data[BIT_EN];
            sens <= sens_e'({wr_data[BIT_LV], wr_data[BIT_EDG]});
        end
    end

    // Sticky flag: an enabled trigger takes priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (trig && en) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // Assemble the readable register image
    always_comb begin
        rd_word           = '0;
        rd_word[BIT_FLAG] = flag;
        rd_word[BIT_EN]   = en;
        rd_word[BIT_LV]   = sens[1];
        rd_word[BIT_EDG]  = sens[0];
        rd_word[BIT_PIN]  = level;
    end
endmodule

// File: rtl/extirq_ctrl.sv
// Module: top of the external interrupt controller. Decodes the register bus
// and builds the shared request.
// Assumes channel k is at address BASE_ADDR + k, with a combinational read.
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int ADDR_W      = 4,
    parameter int BASE_ADDR   = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] flag_vec;
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] trig_vec;
    logic [NUM_CH-1:0] clr_vec;
    logic [REG_W-1:0]  words [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign hit[g] = (addr == ADDR_W'(BASE_ADDR + g));

        extirq_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[g]),
            .wr_sel  (wr_en & hit[g]),
            .wr_data (wr_data),
            .rd_word (words[g]),
            .flag    (flag_vec[g]),
            .en      (en_vec[g]),
            .trig    (trig_vec[g]),
            .clr     (clr_vec[g])
        );
    end

    // Return the addressed channel's register, or zero for other addresses
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (hit[k]) rd_data = rd_data | words[k];
        end
    end

    // Shared request: any channel with an enabled, pending flag
    assign irq = |(flag_vec & en_vec);
endmodule

// File: rtl/extirq_ctrl_chk.sv
// Module: assertion checker for extirq_ctrl, attached by bind.
// Assumes it is bound into the top so that the per-channel vectors are visible.
module extirq_ctrl_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rd_data,
    input logic              irq,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] trig_vec,
    input logic [NUM_CH-1:0] clr_vec
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_vec == '0 && en_vec == '0));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:6] == 2'b00 && rd_data[1] == 1'b0));

    assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_flag_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[i]) |-> $past(en_vec[i]));

        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !(trig_vec[i] && en_vec[i])) |=> !flag_vec[i]);

        assert_trig_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_vec[i] && en_vec[i]) |=> flag_vec[i]);
    end
endmodule

bind extirq_ctrl extirq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (rd_data),
    .irq      (irq),
    .flag_vec (flag_vec),
    .en_vec   (en_vec),
    .trig_vec (trig_vec),
    .clr_vec  (clr_vec)
);

// File: tb/extirq_ctrl_test.sv
// Bench: directed stimulus plus a per-clock behavioural model compared on
// every falling clock edge.
module extirq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pins = 2'b00;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;

    // Behavioural model state
    int m_s1[2], m_s2[2], m_prev[2], m_flag[2], m_en[2], m_lv[2], m_edg[2];

    extirq_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pins),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance the model once per rising edge
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_s1[c] = 0; m_s2[c] = 0; m_prev[c] = 0; m_flag[c] = 0;
                m_en[c] = 0; m_lv[c] = 0; m_edg[c] = 0;
            end else begin
                bit sel, rise_e, fall_e, fire;
                sel    = wr_en && (addr == c);
                rise_e = (m_s2[c] == 1) && (m_prev[c] == 0);
                fall_e = (m_s2[c] == 0) && (m_prev[c] == 1);
                if (m_edg[c] == 1) fire = rise_e || (m_lv[c] == 1 && m_s2[c] == 1);
                else               fire = fall_e || (m_lv[c] == 1 && m_s2[c] == 0);
                if (fire && m_en[c] == 1)     m_flag[c] = 1;
                else if (sel && wr_data[1])   m_flag[c] = 0;
                if (sel) begin
                    m_en[c]  = wr_data[4];
                    m_lv[c]  = wr_data[3];
                    m_edg[c] = wr_data[2];
                end
                m_prev[c] = m_s2[c];
                m_s2[c]   = m_s1[c];
                m_s1[c]   = pins[c];
            end
        end
    end

    function automatic logic [7:0] model_word(int c);
        model_word = {2'b00, m_flag[c][0], m_en[c][0], m_lv[c][0], m_edg[c][0], 1'b0, m_s2[c][0]};
    endfunction

    // Compare the read port and request line against the model on every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [7:0] exp_rd;
            logic       exp_irq;
            exp_rd  = (addr < 2) ? model_word(int'(addr)) : 8'h00;
            exp_irq = (m_flag[0] == 1 && m_en[0] == 1) || (m_flag[1] == 1 && m_en[1] == 1);
            checks++;
            if (rd_data !== exp_rd) begin
                fails++;
                $display("FAIL R2 per-cycle rd_data actual=%h expected=%h", rd_data, exp_rd);
            end
            checks++;
            if (irq !== exp_irq) begin
                fails++;
                $display("FAIL R10 per-cycle irq actual=%b expected=%b", irq, exp_irq);
            end
        end
    end

    task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = w; addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, addr, 8'h00);
    endtask

    task automatic set_pin(input int c, input logic v);
        @(negedge clk); #1;
        wr_en = 1'b0; pins[c] = v;
    endtask

    task automatic read_check(input int c, input logic [7:0] mask,
                              input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        wr_en = 1'b0; addr = 4'(c);
        #2;
        checks++;
        if ((rd_data & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s ch%0d actual=%h expected=%h", tag, c, rd_data & mask, exp & mask);
        end
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk); #3;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1; cmp_on = 1;
        read_check(0, 8'hFF, 8'h00, "R1");
        read_check(1, 8'hFF, 8'h00, "R1");
        check_irq(1'b0, "R1");

        // R3: falling-edge mode
        step(1'b1, 4'd0, 8'h10);
        set_pin(0, 1'b1); idle(4);
        read_check(0, 8'hFF, 8'h11, "R3 rise ignored");
        set_pin(0, 1'b0); idle(4);
        read_check(0, 8'hFF, 8'h30, "R3");
        check_irq(1'b1, "R10");

        // R7 clear, R12 ignored bits
        step(1'b1, 4'd0, 8'h12);
        read_check(0, 8'hFF, 8'h10, "R7");
        step(1'b1, 4'd0, 8'h31);
        read_check(0, 8'hFF, 8'h10, "R12");

        // R4: rising-edge mode, clear while pin high holds
        step(1'b1, 4'd0, 8'h14);
        set_pin(0, 1'b1); idle(4);
        read_check(0, 8'hFF, 8'h35, "R4");
        step(1'b1, 4'd0, 8'h16);
        idle(2);
        read_check(0, 8'hFF, 8'h15, "R4 clear holds");

        // R6: rising plus high level, clear overridden while high (R11)
        step(1'b1, 4'd0, 8'h1C);
        idle(2);
        read_check(0, 8'hFF, 8'h3D, "R6");
        step(1'b1, 4'd0, 8'h1E);
        read_check(0, 8'hFF, 8'h3D, "R11");
        set_pin(0, 1'b0); idle(4);
        step(1'b1, 4'd0, 8'h1E);
        read_check(0, 8'hFF, 8'h1C, "R6 clear after low");

        // R5: falling plus low level
        step(1'b1, 4'd0, 8'h18);
        idle(2);
        read_check(0, 8'hFF, 8'h38, "R5");
        step(1'b1, 4'd0, 8'h1A);
        read_check(0, 8'hFF, 8'h38, "R5 clear overridden");
        set_pin(0, 1'b1); idle(4);
        step(1'b1, 4'd0, 8'h1A);
        read_check(0, 8'hFF, 8'h19, "R5 clear after high");

        // R8: synchronizer latency on the pin bit
        set_pin(0, 1'b0);
        read_check(0, 8'h01, 8'h01, "R8 one edge");
        read_check(0, 8'h01, 8'h00, "R8 two edges");
        step(1'b1, 4'd0, 8'h00);
        step(1'b1, 4'd0, 8'h02);
        read_check(0, 8'hFF, 8'h00, "R9 disabled ch0");

        // R9: disabled channel 1 misses an edge
        set_pin(1, 1'b1); idle(4);
        set_pin(1, 1'b0); idle(4);
        read_check(1, 8'hFF, 8'h00, "R9");
        step(1'b1, 4'd1, 8'h10);
        read_check(1, 8'hFF, 8'h10, "R9 late enable");

        // R10 / R13: channel 1 fires, channel 0 untouched
        set_pin(1, 1'b1); idle(4);
        read_check(1, 8'hFF, 8'h11, "R3 ch1 rise ignored");
        set_pin(1, 1'b0); idle(4);
        read_check(1, 8'hFF, 8'h30, "R13 ch1 flag");
        read_check(0, 8'hFF, 8'h00, "R13 ch0 untouched");
        check_irq(1'b1, "R10");
        step(1'b1, 4'd1, 8'h00);
        read_check(1, 8'hFF, 8'h20, "R10 flag kept");
        check_irq(1'b0, "R10 gated");
        step(1'b1, 4'd1, 8'h10);
        check_irq(1'b1, "R10 re-enabled");
        step(1'b1, 4'd1, 8'h12);
        check_irq(1'b0, "R7 ch1 cleared");
        read_check(2, 8'hFF, 8'h00, "R2 unmapped");

        idle(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule